// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register Bank

This block holds the software-visible control and status state for a two-channel descriptor DMA engine. Each channel sees its own window of word registers: a control word, a status word, a current-descriptor pointer, a tail-descriptor pointer, and spare words that simply hold what was written. Software reads and writes the bank with single-word strobes on a plain register bus. Read data comes back one cycle later.

The bank applies the channel semantics itself. It handles soft reset with a one-access delay, run/stop with the halted and idle flags, write-one-to-clear interrupt flags, and an interrupt line per channel gated by mask bits in control. Towards the descriptor engine it exports run, idle and halted per channel. It raises a one-cycle kick when software moves channel 0's tail pointer. It accepts strobes from the engine that set idle or set interrupt flags. The coalescing counter and the delay timer live in the engine. Their current values are mirrored into the upper bytes of the status readback.

Top module: `xfer_csr_bank`

## Requirements
- R1: After `rst_n` is released, each channel's control reads 0x00010002 and its status reads with bits 15:0 equal to 0x0001. The outputs show run=0, halted=1 and idle=0.
- R2: The channel is (addr / 48) mod 2 and the register index is (addr mod 48) >> 2. Control is at 0x00, status at 0x04, current descriptor at 0x08 and tail at 0x10, so 0x68 reaches channel 0 at 0x08 and 0x90 reaches channel 1's control.
- R3: A control write with no reset pending and data bit 2 clear stores the data with bit 1 forced to 1.
- R4: A control write whose data bit 2 is set, or any control write while a reset is pending, does three things. It loads control with 0x00010006, sets status to halted only with idle and flags cleared, and drops run, whatever the data.
- R5: A control read returns the word with bit 2 cleared, and it clears the pending reset bit.
- R6: A control write with bit 0 set, bit 2 clear and no reset pending clears halted and idle. The run output follows control bit 0.
- R7: Status bits 14:12 are interrupt flags. Writing 1 clears a flag and writing never sets one. An engine set strobe in the same cycle wins over a clear. Other status bits ignore writes.
- R8: A status read returns the delay-timer mirror in bits 31:24 and the completion-counter mirror in bits 23:16. It returns the flags in 14:12, idle in bit 1 and halted in bit 0, with all other bits 0.
- R9: A tail write stores the pointer and clears idle. One cycle later `kick` pulses for one cycle, and only for channel 0.
- R10: `irq[c]` is high exactly when some bit of status[14:12] AND control[14:12] of channel c is set.
- R11: `rvalid` and `rdata` appear in the cycle after `rd`.
- R12: The current-descriptor word, the tail word and every other word in the window read back the last value written to them.
- R13: An engine idle strobe sets idle on its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| eng_idle_set | input | NCH | Engine strobe: set idle per channel |
| eng_flag_set | input | NCH*3 | Engine strobe: set interrupt flags, 3 per channel |
| coal_cnt | input | NCH*8 | Live completion counter per channel |
| dly_cnt | input | NCH*8 | Live delay timer count per channel |
| run | output | NCH | Control run bit per channel |
| idle | output | NCH | Idle flag per channel |
| halted | output | NCH | Halted flag per channel |
| kick | output | 1 | Start pulse after channel 0 tail write |
| irq | output | NCH | Interrupt per channel |

## Verification
The bench targets the reset-pending window. A control write there must reapply reset rather than start the channel, so a design that honours the run bit would report halted low too early. A second read must show the bit already gone; a design without the read-clear keeps the channel stuck in reset. Write-one-to-clear is driven with ones on flags that are already clear, and with a clear colliding with an engine set in the same cycle. A wrong design either sets flags from software or loses an engine event. Address aliasing above the two windows, the kick on channel 1 tail writes, and the live mirror bytes in status are all checked; a decode slip shows up as a wrong word or a spurious kick.

// File: rtl/xfer_csr_pkg.sv
package xfer_csr_pkg;
    localparam int DATA_W    = 32;
    localparam int WIN_BYTES = 48;
    localparam int WIN_WORDS = WIN_BYTES / 4;
    localparam int IDX_W     = $clog2(WIN_WORDS);
    localparam int NFLAG     = 3;
    localparam int FLAG_LSB  = 12;
    localparam int MIR_W     = 8;

    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_TAIL = IDX_W'(4);

    localparam int BIT_RUN  = 0;
    localparam int BIT_TAIL = 1;
    localparam int BIT_SRST = 2;

    localparam logic [DATA_W-1:0] CTRL_INIT = 32'h0001_0002;

    typedef struct packed {
        logic [DATA_W-1:0]                ctrl;
        logic                             halted;
        logic                             idle;
        logic [NFLAG-1:0]                 flags;
        logic [WIN_WORDS-1:0][DATA_W-1:0] words;
    } chan_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              kick;
    } bank_state_t;
endpackage

// File: rtl/xfer_csr_decode.sv
module xfer_csr_decode
    import xfer_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCH    = 2,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] quot;
    logic [ADDR_W-1:0] rem;

    always_comb begin
        quot = addr / ADDR_W'(WIN_BYTES);
        rem  = addr % ADDR_W'(WIN_BYTES);
        ch   = quot[CH_W-1:0];
        idx  = rem[IDX_W+1:2];
    end
endmodule

// File: rtl/xfer_csr_chan.sv
module xfer_csr_chan
    import xfer_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              idle_set,
    input  logic [NFLAG-1:0]  flag_set,
    input  logic [MIR_W-1:0]  coal_val,
    input  logic [MIR_W-1:0]  dly_val,
    output logic [DATA_W-1:0] rd_word,
    output logic              run,
    output logic              idle,
    output logic              halted,
    output logic              irq
);
    chan_state_t s_d, s_q;
    logic [DATA_W-1:0] ctrl_new;

    always_comb begin
        s_d      = s_q;
        ctrl_new = wdata | DATA_W'(1 << BIT_TAIL) | (s_q.ctrl & DATA_W'(1 << BIT_SRST));
        if (rd_en && idx == IDX_CTRL) begin
            s_d.ctrl[BIT_SRST] = 1'b0;
        end
        if (wr_en) begin
            if (idx == IDX_CTRL) begin
                if (ctrl_new[BIT_SRST]) begin
                    s_d.ctrl   = CTRL_INIT | DATA_W'(1 << BIT_SRST);
                    s_d.halted = 1'b1;
                    s_d.idle   = 1'b0;
                    s_d.flags  = '0;
                end else begin
                    s_d.ctrl = ctrl_new;
                    if (ctrl_new[BIT_RUN]) begin
                        s_d.halted = 1'b0;
                        s_d.idle   = 1'b0;
                    end
                end
            end else if (idx == IDX_STAT) begin
                s_d.flags = s_q.flags & ~wdata[FLAG_LSB +: NFLAG];
            end else if (int'(idx) < WIN_WORDS) begin
                s_d.words[idx] = wdata;
                if (idx == IDX_TAIL) begin
                    s_d.idle = 1'b0;
                end
            end
        end
        if (idle_set) begin
            s_d.idle = 1'b1;
        end
        s_d.flags = s_d.flags | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl   <= CTRL_INIT;
            s_q.halted <= 1'b1;
            s_q.idle   <= 1'b0;
            s_q.flags  <= '0;
            s_q.words  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (idx == IDX_CTRL) begin
            rd_word = s_q.ctrl & ~DATA_W'(1 << BIT_SRST);
        end else if (idx == IDX_STAT) begin
            rd_word = {dly_val, coal_val, 1'b0, s_q.flags, 10'b0, s_q.idle, s_q.halted};
        end else if (int'(idx) < WIN_WORDS) begin
            rd_word = s_q.words[idx];
        end else begin
            rd_word = '0;
        end
        run    = s_q.ctrl[BIT_RUN];
        idle   = s_q.idle;
        halted = s_q.halted;
        irq    = |(s_q.flags & s_q.ctrl[FLAG_LSB +: NFLAG]);
    end

    // R5: a control read leaves no reset pending
    a_r5_read_clears_srst: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && idx == IDX_CTRL) |=> !s_q.ctrl[BIT_SRST]);

    // R4: reset request halts and stops the channel
    a_r4_srst_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_CTRL && (wdata[BIT_SRST] || s_q.ctrl[BIT_SRST])) |=> (halted && !run));

    // R6: run write with no reset clears halted and idle
    a_r6_run_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_CTRL && wdata[BIT_RUN] && !wdata[BIT_SRST]
         && !s_q.ctrl[BIT_SRST] && !idle_set) |=> (!halted && !idle && run));

    // R7: a status write from the bus never sets a flag
    a_r7_w1c_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_STAT && flag_set == '0) |=> ((s_q.flags & ~$past(s_q.flags)) == '0));
endmodule

// File: rtl/xfer_csr_bank.sv
module xfer_csr_bank
    import xfer_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCH    = 2,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic                   rd,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rvalid,
    input  logic [NCH-1:0]         eng_idle_set,
    input  logic [NCH*NFLAG-1:0]   eng_flag_set,
    input  logic [NCH*MIR_W-1:0]   coal_cnt,
    input  logic [NCH*MIR_W-1:0]   dly_cnt,
    output logic [NCH-1:0]         run,
    output logic [NCH-1:0]         idle,
    output logic [NCH-1:0]         halted,
    output logic                   kick,
    output logic [NCH-1:0]         irq
);
    logic [CH_W-1:0]              sel_ch;
    logic [IDX_W-1:0]             sel_idx;
    logic [NCH-1:0][DATA_W-1:0]   rd_words;
    bank_state_t                  b_d, b_q;

    xfer_csr_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .addr (addr),
        .ch   (sel_ch),
        .idx  (sel_idx)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        assign hit = (int'(sel_ch) == c);
        xfer_csr_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr && hit),
            .rd_en    (rd && hit),
            .idx      (sel_idx),
            .wdata    (wdata),
            .idle_set (eng_idle_set[c]),
            .flag_set (eng_flag_set[c*NFLAG +: NFLAG]),
            .coal_val (coal_cnt[c*MIR_W +: MIR_W]),
            .dly_val  (dly_cnt[c*MIR_W +: MIR_W]),
            .rd_word  (rd_words[c]),
            .run      (run[c]),
            .idle     (idle[c]),
            .halted   (halted[c]),
            .irq      (irq[c])
        );
    end

    always_comb begin
        b_d        = b_q;
        b_d.rvalid = rd;
        if (rd) begin
            b_d.rdata = rd_words[sel_ch];
        end
        b_d.kick = wr && sel_ch == '0 && sel_idx == IDX_TAIL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rdata  = b_q.rdata;
    assign rvalid = b_q.rvalid;
    assign kick   = b_q.kick;

    // R9: kick only follows a channel 0 tail write
    a_r9_kick_ch0_only: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> $past(wr && sel_ch == '0 && sel_idx == IDX_TAIL));

    // R11: read data one cycle after the strobe
    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
endmodule

// File: tb/xfer_csr_bank_tb.sv
module xfer_csr_bank_tb;
    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic [NCH-1:0]    eng_idle_set = '0;
    logic [NCH*3-1:0]  eng_flag_set = '0;
    logic [NCH*8-1:0]  coal_cnt = '0;
    logic [NCH*8-1:0]  dly_cnt = '0;
    logic [NCH-1:0]    run, idle, halted, irq;
    logic              kick;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    xfer_csr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .eng_idle_set(eng_idle_set),
        .eng_flag_set(eng_flag_set), .coal_cnt(coal_cnt), .dly_cnt(dly_cnt),
        .run(run), .idle(idle), .halted(halted), .kick(kick), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    // monitor: pop and compare every returned read
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 run", {30'b0, run}, 32'd0);
        chk("R1 halted", {30'b0, halted}, 32'd3);
        chk("R1 idle", {30'b0, idle}, 32'd0);
        chk("R11 rvalid low idle", {31'b0, rvalid}, 32'd0);
        rd_reg(8'h00, 32'h0001_0002, "R1 ch0 control");
        rd_reg(8'h04, 32'h0000_0001, "R1 ch0 status");
        rd_reg(8'h34, 32'h0000_0001, "R1 ch1 status");

        // R3 / R6 run with irq mask bit 12
        wr_reg(8'h00, 32'h0000_1001);
        rd_reg(8'h00, 32'h0000_1003, "R3 control tail bit forced");
        chk("R6 run", {31'b0, run[0]}, 32'd1);
        chk("R6 halted cleared", {31'b0, halted[0]}, 32'd0);

        // R10 / R8 flags from engine, mirrors in status
        coal_cnt = 16'h005A; dly_cnt = 16'h00C3;
        @(negedge clk); eng_flag_set = 6'b000_010;
        @(negedge clk); eng_flag_set = '0;
        chk("R10 masked flag no irq", {31'b0, irq[0]}, 32'd0);
        @(negedge clk); eng_flag_set = 6'b000_001;
        @(negedge clk); eng_flag_set = '0;
        chk("R10 irq asserted", {31'b0, irq[0]}, 32'd1);
        chk("R10 other channel quiet", {31'b0, irq[1]}, 32'd0);
        rd_reg(8'h04, 32'hC35A_3000, "R8 status layout");

        // R7 write one to clear, writing never sets
        wr_reg(8'h04, 32'h0000_1000);
        chk("R7 R10 irq cleared", {31'b0, irq[0]}, 32'd0);
        rd_reg(8'h04, 32'hC35A_2000, "R7 w1c");
        wr_reg(8'h04, 32'hFFFF_4FFF);
        rd_reg(8'h04, 32'hC35A_2000, "R7 write never sets");

        // R13 / R9 idle and kick
        @(negedge clk); eng_idle_set = 2'b01;
        @(negedge clk); eng_idle_set = '0;
        chk("R13 idle set", {31'b0, idle[0]}, 32'd1);
        wr_reg(8'h10, 32'h0000_0040);
        chk("R9 kick ch0", {31'b0, kick}, 32'd1);
        chk("R9 idle cleared", {31'b0, idle[0]}, 32'd0);
        @(negedge clk);
        chk("R9 kick one cycle", {31'b0, kick}, 32'd0);
        rd_reg(8'h10, 32'h0000_0040, "R12 tail readback");
        @(negedge clk); eng_idle_set = 2'b10;
        @(negedge clk); eng_idle_set = '0;
        wr_reg(8'h40, 32'h0000_0080);
        chk("R9 no kick ch1", {31'b0, kick}, 32'd0);
        chk("R9 ch1 idle cleared", {31'b0, idle[1]}, 32'd0);

        // R12 / R2 storage and decode
        wr_reg(8'h38, 32'h0000_1234);
        rd_reg(8'h38, 32'h0000_1234, "R12 ch1 current descriptor");
        wr_reg(8'h2C, 32'hDEAD_BEEF);
        rd_reg(8'h2C, 32'hDEAD_BEEF, "R12 unmapped word");
        wr_reg(8'h08, 32'hAAAA_0000);
        rd_reg(8'h68, 32'hAAAA_0000, "R2 alias to ch0");
        rd_reg(8'h90, 32'h0001_0002, "R2 alias to ch1 control");
        rd_reg(8'h5C, 32'h0000_0000, "R2 ch1 word 11 separate");

        // R4 / R5 soft reset with pending window
        wr_reg(8'h00, 32'h0000_0004);
        chk("R4 run dropped", {31'b0, run[0]}, 32'd0);
        chk("R4 halted", {31'b0, halted[0]}, 32'd1);
        rd_reg(8'h04, 32'hC35A_0001, "R4 status after reset");
        wr_reg(8'h00, 32'h0000_0001);
        chk("R4 run ignored while pending", {31'b0, halted[0]}, 32'd1);
        chk("R4 run stays low", {31'b0, run[0]}, 32'd0);
        rd_reg(8'h00, 32'h0001_0002, "R5 read hides reset bit");
        wr_reg(8'h00, 32'h0000_0001);
        chk("R5 R6 run after clear", {31'b0, halted[0]}, 32'd0);
        rd_reg(8'h00, 32'h0000_0003, "R5 reset no longer pending");

        // R7 engine set wins over same-cycle clear
        @(negedge clk);
        wr = 1'b1; addr = 8'h04; wdata = 32'h0000_4000; eng_flag_set = 6'b000_100;
        @(negedge clk);
        wr = 1'b0; eng_flag_set = '0;
        rd_reg(8'h04, 32'hC35A_4000, "R7 engine set wins");

        repeat (3) @(negedge clk);
        chk("R11 all reads returned", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule